// File: doc/BRIEF.md
# NAND Sector Hamming Code Checker and Corrector

This block decides, for each 512-byte sector read from NAND flash, whether the data is clean, carries a single flipped bit that can be repaired, or is beyond repair. For every sector it receives two 3-byte Hamming codes. The first is the code that was stored in the spare area when the page was programmed. The second is the code that the read-path parity logic computed over the data just read. Each packed code is expanded into even and odd line/column parity pairs and regrouped. The two regrouped codes are XORed into a 24-bit syndrome. The number of ones in the syndrome selects the verdict. For a repairable sector, the block reports the byte offset and bit index that software or a downstream fixer must invert.

A start pulse opens a page of either one sector or four sectors. The sequencer then takes one code pair per sector through a valid/ready handshake and reports each sector as it finishes. It ends the page with a done strobe and a held page verdict. The page stops early at the first sector that cannot be repaired.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset, pair_ready, rpt_valid and done are 0 and res_status is 2'b00.
- R2: Code bytes are packed as bits [7:0] byte0, [15:8] byte1, [23:16] byte2. The even parity of stage k (k = 0..11) sits at byte0 bit k for k<8 and at byte2 bit k-8 otherwise. The odd parity of stage k sits at byte1 bit k for k<8 and at byte2 bit k-4 otherwise. Syndrome bit 2k is the XOR of the two even parities of stage k, and bit 2k+1 is the XOR of the two odd parities.
- R3: A pair whose two codes are equal is reported clean on the cycle after it is accepted. A differing pair is reported one cycle later than that.
- R4: A syndrome with exactly twelve ones reports status 2'b01. The byte offset is syndrome bits 23,21,19,17,15,13,11,9,7 (MSB first) and the bit index is bits 5,3,1 (MSB first).
- R5: A syndrome with exactly one or exactly eleven ones reports status 2'b10.
- R6: A stored code of 24'hFFFFFF with a computed code of 24'h000000 reports clean, since it is an erased sector. An all-ones stored code with any other computed code is judged by count alone.
- R7: Any other nonzero count reports status 2'b10. rpt_byte and rpt_bit are zero for every status other than 2'b01.
- R8: Status encoding is 2'b00 clean, 2'b01 corrected, 2'b10 uncorrectable. res_status holds the most severe status of the page and res_sector holds the last reported sector. Both stay unchanged until the next accepted start, which clears them to zero.
- R9: With multi_sector=1 a page has four sectors, reported with indices 0,1,2,3. With multi_sector=0 it has one sector, index 0. done pulses together with the report of the final sector.
- R10: An uncorrectable sector ends the page: done pulses with its report and no further pair is accepted.
- R11: start is ignored while a page is in progress.
- R12: A pair is taken only when pair_valid and pair_ready are both high. pair_ready is high only while the block waits for the next sector of an open page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a page when idle |
| multi_sector | input | 1 | Page size at start: 1 = four sectors, 0 = one |
| pair_valid | input | 1 | Code pair present |
| pair_ready | output | 1 | Block accepts a code pair |
| code_stored | input | 24 | Packed code read from the spare area |
| code_calc | input | 24 | Packed code computed over the read data |
| rpt_valid | output | 1 | One-cycle sector report strobe |
| rpt_sector | output | 2 | Index of the reported sector |
| rpt_status | output | 2 | Sector verdict |
| rpt_byte | output | 9 | Byte offset to invert |
| rpt_bit | output | 3 | Bit index to invert |
| done | output | 1 | Page finished strobe |
| res_status | output | 2 | Held page verdict |
| res_sector | output | 2 | Held index of last reported sector |

## Verification
The hardest case to reach is a genuine single-bit data error: it needs a code pair whose syndrome has twelve ones arranged as complementary even/odd pairs. The stimulus therefore never touches data. For each of the 4096 bit addresses, the bench builds the syndrome from the address bits, packs it into a code difference with its own layout arithmetic, and XORs it onto a varying stored code. Separate sweeps cover every population count from 0 to 24, the erased-page corner cases, and pages cut short at an uncorrectable sector.

// File: rtl/necc_pkg.sv
package necc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_BAD   = 2'b10
  } ecc_status_e;

  localparam int CODE_W   = 24;
  localparam int STAGES   = CODE_W / 2;
  localparam int CODE_ONE = (1 << CODE_W) - 1;
endpackage

// File: rtl/necc_regroup.sv
module necc_regroup #(
  parameter int CODE_W = 24
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] grp
);
  localparam int ST = CODE_W / 2;

  logic [ST-1:0] even_p;
  logic [ST-1:0] odd_p;

  // unpack: low nibble of byte2 continues the even chain, high nibble the odd chain
  assign even_p = {code[19:16], code[7:0]};
  assign odd_p  = {code[23:20], code[15:8]};

  // group 0: stages 3..6, group 1: stages 7..10
  for (genvar k = 0; k < 4; k++) begin : g_mid
    assign grp[2*k]       = even_p[3+k];
    assign grp[2*k+1]     = odd_p[3+k];
    assign grp[8+2*k]     = even_p[7+k];
    assign grp[8+2*k+1]   = odd_p[7+k];
  end
  // group 2: top stage first, then stages 0..2
  assign grp[16] = even_p[11];
  assign grp[17] = odd_p[11];
  for (genvar k = 0; k < 3; k++) begin : g_low
    assign grp[18+2*k] = even_p[k];
    assign grp[19+2*k] = odd_p[k];
  end
endmodule

// File: rtl/necc_syndrome.sv
module necc_syndrome #(
  parameter int CODE_W = 24
) (
  input  logic [CODE_W-1:0] grp_a,
  input  logic [CODE_W-1:0] grp_b,
  output logic [CODE_W-1:0] syn
);
  logic [CODE_W-1:0] diff;

  assign diff = grp_a ^ grp_b;

  // reorder so that bit 2k / 2k+1 hold the even / odd parity of stage k
  assign syn[5:0]   = diff[23:18];
  assign syn[13:6]  = diff[7:0];
  assign syn[21:14] = diff[15:8];
  assign syn[22]    = diff[16];
  assign syn[23]    = diff[17];
endmodule

// File: rtl/necc_classify.sv
module necc_classify
  import necc_pkg::*;
#(
  parameter int BIT_W  = 3,
  parameter int OFF_W  = 9
) (
  input  logic [2*(BIT_W+OFF_W)-1:0] syn,
  input  logic                       erased,
  output ecc_status_e                status,
  output logic [OFF_W-1:0]           fix_byte,
  output logic [BIT_W-1:0]           fix_bit
);
  localparam int LOC_W = BIT_W + OFF_W;
  localparam int SYN_W = 2 * LOC_W;
  localparam int CNT_W = $clog2(SYN_W + 1);

  logic [CNT_W-1:0] ones;
  logic [LOC_W-1:0] loc;

  always_comb begin
    ones = '0;
    for (int i = 0; i < SYN_W; i++) ones = ones + CNT_W'(syn[i]);
  end

  for (genvar j = 0; j < LOC_W; j++) begin : g_loc
    assign loc[j] = syn[2*j+1];
  end

  always_comb begin
    status   = ST_BAD;
    fix_byte = '0;
    fix_bit  = '0;
    if (ones == '0) begin
      status = ST_CLEAN;
    end else if (ones == CNT_W'(1) || ones == CNT_W'(LOC_W - 1)) begin
      status = ST_BAD;
    end else if (ones == CNT_W'(LOC_W)) begin
      status   = ST_FIXED;
      fix_byte = loc[LOC_W-1:BIT_W];
      fix_bit  = loc[BIT_W-1:0];
    end else if (erased) begin
      status = ST_CLEAN;
    end
  end
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
  import necc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAGE_SECTORS = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic                            multi_sector,
  input  logic                            pair_valid,
  output logic                            pair_ready,
  input  logic [CODE_W-1:0]               code_stored,
  input  logic [CODE_W-1:0]               code_calc,
  output logic                            rpt_valid,
  output logic [$clog2(PAGE_SECTORS)-1:0] rpt_sector,
  output logic [1:0]                      rpt_status,
  output logic [$clog2(SECTOR_BYTES)-1:0] rpt_byte,
  output logic [2:0]                      rpt_bit,
  output logic                            done,
  output logic [1:0]                      res_status,
  output logic [$clog2(PAGE_SECTORS)-1:0] res_sector
);
  localparam int OFF_W  = $clog2(SECTOR_BYTES);
  localparam int BIT_W  = 3;
  localparam int SIDX_W = $clog2(PAGE_SECTORS);

  typedef enum logic [1:0] {S_IDLE, S_TAKE, S_JUDGE} seq_state_e;

  seq_state_e        state;
  logic [SIDX_W-1:0] sect;
  logic [SIDX_W-1:0] last_sect;
  logic [CODE_W-1:0] grp_st, grp_ca, syn_w, syn_q;
  logic              erased_q;
  ecc_status_e       cls_status;
  logic [OFF_W-1:0]  cls_byte;
  logic [BIT_W-1:0]  cls_bit;
  logic              at_last;

  necc_regroup #(.CODE_W(CODE_W)) i_grp_st (.code(code_stored), .grp(grp_st));
  necc_regroup #(.CODE_W(CODE_W)) i_grp_ca (.code(code_calc),   .grp(grp_ca));
  necc_syndrome #(.CODE_W(CODE_W)) i_syn (.grp_a(grp_st), .grp_b(grp_ca), .syn(syn_w));
  necc_classify #(.BIT_W(BIT_W), .OFF_W(OFF_W)) i_cls (
    .syn(syn_q), .erased(erased_q),
    .status(cls_status), .fix_byte(cls_byte), .fix_bit(cls_bit)
  );

  assign pair_ready = (state == S_TAKE);
  assign at_last    = (sect == last_sect);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      sect       <= '0;
      last_sect  <= '0;
      syn_q      <= '0;
      erased_q   <= 1'b0;
      rpt_valid  <= 1'b0;
      rpt_sector <= '0;
      rpt_status <= ST_CLEAN;
      rpt_byte   <= '0;
      rpt_bit    <= '0;
      done       <= 1'b0;
      res_status <= ST_CLEAN;
      res_sector <= '0;
    end else begin
      rpt_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_TAKE;
            sect       <= '0;
            last_sect  <= multi_sector ? SIDX_W'(PAGE_SECTORS - 1) : '0;
            res_status <= ST_CLEAN;
            res_sector <= '0;
          end
        end
        S_TAKE: begin
          if (pair_valid) begin
            if (code_stored == code_calc) begin
              rpt_valid  <= 1'b1;
              rpt_sector <= sect;
              rpt_status <= ST_CLEAN;
              rpt_byte   <= '0;
              rpt_bit    <= '0;
              res_sector <= sect;
              if (at_last) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                sect <= sect + SIDX_W'(1);
              end
            end else begin
              syn_q    <= syn_w;
              erased_q <= (code_stored == CODE_W'(CODE_ONE)) && (code_calc == '0);
              state    <= S_JUDGE;
            end
          end
        end
        S_JUDGE: begin
          rpt_valid  <= 1'b1;
          rpt_sector <= sect;
          rpt_status <= cls_status;
          rpt_byte   <= cls_byte;
          rpt_bit    <= cls_bit;
          res_sector <= sect;
          if (cls_status > res_status) res_status <= cls_status;
          if (cls_status == ST_BAD || at_last) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            sect  <= sect + SIDX_W'(1);
            state <= S_TAKE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_corrector_chk.sv
module nand_ecc_corrector_chk #(
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              pair_valid,
  input logic              pair_ready,
  input logic [CODE_W-1:0] code_stored,
  input logic [CODE_W-1:0] code_calc,
  input logic              rpt_valid,
  input logic [1:0]        rpt_status,
  input logic [8:0]        rpt_byte,
  input logic [2:0]        rpt_bit,
  input logic              done,
  input logic [1:0]        res_status
);
  AST_EQUAL_FAST: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && pair_ready && code_stored == code_calc) |=> (rpt_valid && rpt_status == 2'b00)); // R3

  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_status != 2'b01) |-> (rpt_byte == '0 && rpt_bit == '0)); // R7

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> (rpt_status != 2'b11)); // R8

  AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_status) |-> (rpt_valid || $past(start))); // R8

  AST_DONE_WITH_RPT: assert property (@(posedge clk) disable iff (rst)
    done |-> rpt_valid); // R9

  AST_BAD_ENDS: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_status == 2'b10) |-> done); // R10

  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !pair_ready); // R12
endmodule

bind nand_ecc_corrector nand_ecc_corrector_chk i_chk (
  .clk(clk), .rst(rst), .start(start), .pair_valid(pair_valid),
  .pair_ready(pair_ready), .code_stored(code_stored), .code_calc(code_calc),
  .rpt_valid(rpt_valid), .rpt_status(rpt_status), .rpt_byte(rpt_byte),
  .rpt_bit(rpt_bit), .done(done), .res_status(res_status)
);

// File: tb/test_nand_ecc_corrector.sv
`timescale 1ns/1ps
module test_nand_ecc_corrector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        multi_sector = 1'b0;
  logic        pair_valid = 1'b0;
  logic        pair_ready;
  logic [23:0] code_stored = '0;
  logic [23:0] code_calc = '0;
  logic        rpt_valid;
  logic [1:0]  rpt_sector;
  logic [1:0]  rpt_status;
  logic [8:0]  rpt_byte;
  logic [2:0]  rpt_bit;
  logic        done;
  logic [1:0]  res_status;
  logic [1:0]  res_sector;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nand_ecc_corrector i_nand_ecc_corrector (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pack per-stage even/odd syndrome bits into a 3-byte code difference (R2 layout)
  function automatic logic [23:0] code_of_syn(input logic [23:0] s);
    logic [11:0] ev, od;
    for (int k = 0; k < 12; k++) begin
      ev[k] = s[2*k];
      od[k] = s[2*k+1];
    end
    return {od[11:8], ev[11:8], od[7:0], ev[7:0]};
  endfunction

  function automatic logic [23:0] syn_of_code(input logic [23:0] x);
    logic [11:0] ev, od;
    logic [23:0] s;
    ev = {x[19:16], x[7:0]};
    od = {x[23:20], x[15:8]};
    for (int k = 0; k < 12; k++) begin
      s[2*k]   = ev[k];
      s[2*k+1] = od[k];
    end
    return s;
  endfunction

  task automatic begin_page(input bit multi);
    @(negedge clk);
    start = 1'b1;
    multi_sector = multi;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_sector(input logic [23:0] st, input logic [23:0] ca,
                            input int sidx, input bit exp_done, input string tag);
    logic [23:0] s;
    int cnt, exp_st, exp_byte, exp_bit, wait_n, lat;
    s = syn_of_code(st ^ ca);
    cnt = $countones(s);
    exp_byte = 0;
    exp_bit = 0;
    if (st == ca) exp_st = 0;
    else if (cnt == 1 || cnt == 11) exp_st = 2;
    else if (cnt == 12) begin
      exp_st = 1;
      for (int i = 0; i < 9; i++) exp_byte[i] = s[7+2*i];
      for (int i = 0; i < 3; i++) exp_bit[i] = s[1+2*i];
    end else if (st == 24'hFFFFFF && ca == 24'h0) exp_st = 0;
    else exp_st = 2;
    wait_n = 0;
    @(negedge clk);
    while (!pair_ready && wait_n < 20) begin @(negedge clk); wait_n++; end
    pair_valid = 1'b1;
    code_stored = st;
    code_calc = ca;
    @(negedge clk);
    pair_valid = 1'b0;
    lat = 0;
    while (!rpt_valid && lat < 5) begin @(negedge clk); lat++; end
    chk(rpt_valid == 1'b1, {tag, " R12 report seen"}, rpt_valid, 1);
    chk(rpt_status == exp_st[1:0], {tag, " R8 status"}, rpt_status, exp_st);
    chk(rpt_byte == exp_byte[8:0], {tag, " R4 byte"}, rpt_byte, exp_byte);
    chk(rpt_bit == exp_bit[2:0], {tag, " R4 bit"}, rpt_bit, exp_bit);
    chk(lat == ((st == ca) ? 0 : 1), {tag, " R3 latency"}, lat, (st == ca) ? 0 : 1);
    chk(rpt_sector == sidx[1:0], {tag, " R9 sector"}, rpt_sector, sidx);
    chk(done == exp_done, {tag, " R9 done"}, done, exp_done);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(pair_ready == 1'b0, "R1 ready", pair_ready, 0);
    chk(rpt_valid == 1'b0, "R1 rpt_valid", rpt_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(res_status == 2'b00, "R1 res_status", res_status, 0);

    // R12: valid with no open page is not taken
    pair_valid = 1'b1;
    code_stored = 24'h123456;
    code_calc = 24'h000000;
    repeat (3) begin
      @(negedge clk);
      chk(rpt_valid == 1'b0 && pair_ready == 1'b0, "R12 idle ignores pair", rpt_valid, 0);
    end
    pair_valid = 1'b0;

    // R4 and R2: every single-bit data error location
    for (int bb = 0; bb < 512; bb++) begin
      for (int bi = 0; bi < 8; bi++) begin
        logic [11:0] addr;
        logic [23:0] s, st;
        addr = {bb[8:0], bi[2:0]};
        for (int k = 0; k < 12; k++) begin
          s[2*k+1] = addr[k];
          s[2*k]   = ~addr[k];
        end
        st = 24'(bb * 40503 + bi * 977 + 24'h3C5A1);
        begin_page(1'b0);
        run_sector(st, st ^ code_of_syn(s), 0, 1'b1, "R4 R2 single flip");
      end
    end

    // R5 R7: every population count with two syndrome shapes
    for (int n = 0; n <= 24; n++) begin
      logic [23:0] base, rot;
      base = (n == 24) ? 24'hFFFFFF : 24'((1 << n) - 1);
      rot = 24'((base << ((n * 5) % 24)) | (base >> (24 - ((n * 5) % 24))));
      begin_page(1'b0);
      run_sector(24'h5A3C96, 24'h5A3C96 ^ code_of_syn(base), 0, 1'b1, "R5 R7 count low");
      begin_page(1'b0);
      run_sector(24'hA1B2C3, 24'hA1B2C3 ^ code_of_syn(rot), 0, 1'b1, "R5 R7 count rot");
    end

    // R6 erased corner cases
    begin_page(1'b0);
    run_sector(24'hFFFFFF, 24'h000000, 0, 1'b1, "R6 erased");
    chk(res_status == 2'b00, "R6 erased page verdict", res_status, 0);
    begin_page(1'b0);
    run_sector(24'hFFFFFF, 24'h000001, 0, 1'b1, "R6 erased one bit");
    begin_page(1'b0);
    run_sector(24'hFFFFFE, 24'h000000, 0, 1'b1, "R6 near erased");
    begin_page(1'b0);
    run_sector(24'h000000, 24'hFFFFFF, 0, 1'b1, "R6 inverse erased");

    // R9 R8: four-sector page, most severe verdict held
    begin_page(1'b1);
    run_sector(24'h111111, 24'h111111, 0, 1'b0, "R9 quad s0");
    run_sector(24'h222222, 24'h222222 ^ code_of_syn(24'h555555 ^ 24'hFFF000 ^ 24'hFFF000), 1, 1'b0, "R9 quad s1");
    run_sector(24'h333333, 24'h333333, 2, 1'b0, "R9 quad s2");
    run_sector(24'h444444, 24'h444444 ^ code_of_syn(24'hAAAAAA), 3, 1'b1, "R9 quad s3");
    chk(res_status == 2'b01, "R8 page verdict corrected", res_status, 1);
    chk(res_sector == 2'd3, "R8 page last sector", res_sector, 3);
    repeat (5) @(negedge clk);
    chk(res_status == 2'b01 && res_sector == 2'd3, "R8 verdict held", res_status, 1);

    // R8: new start clears the verdict
    begin_page(1'b1);
    chk(res_status == 2'b00 && res_sector == 2'd0, "R8 start clears", res_status, 0);
    // R10: stop at first uncorrectable sector
    run_sector(24'h0F0F0F, 24'h0F0F0F ^ code_of_syn(24'h555555), 0, 1'b0, "R10 s0");
    run_sector(24'h0F0F0F, 24'h0F0F0E, 1, 1'b1, "R10 s1 bad");
    chk(res_status == 2'b10, "R10 verdict", res_status, 2);
    chk(res_sector == 2'd1, "R10 stop sector", res_sector, 1);
    pair_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(pair_ready == 1'b0 && rpt_valid == 1'b0, "R10 no pair after stop", pair_ready, 0);
    end
    pair_valid = 1'b0;

    // R11: start mid-page does not restart
    begin_page(1'b1);
    run_sector(24'h777777, 24'h777777, 0, 1'b0, "R11 s0");
    begin_page(1'b0);
    run_sector(24'h777777, 24'h777777, 1, 1'b0, "R11 s1 after start");
    run_sector(24'h777777, 24'h777777, 2, 1'b0, "R11 s2");
    run_sector(24'h777777, 24'h777777, 3, 1'b1, "R11 s3");

    // R9: single-sector page ends after index 0
    begin_page(1'b0);
    run_sector(24'h808080, 24'h808080, 0, 1'b1, "R9 single");
    @(negedge clk);
    chk(pair_ready == 1'b0, "R9 single closes page", pair_ready, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule